// File: doc/BRIEF.md
# Digit Readout Multiplexer with Zero Blanking

This block turns an eight-digit decimal counter result into the per-column data for a scanning character readout. An outside scanner picks one display column at a time by index. The block answers on one shared 4-bit bus with that column's BCD value, together with a blank flag and an overflow-symbol select. Column 0 is the least significant digit. Column 7 is the leftmost.

Zeros to the left of the first nonzero digit are blanked. The least significant column is always shown, so a zero count reads as a single "0". A sticky overflow flag is set by a carry out of the top decade and cleared only by the counter clear. While it is set, the leftmost column shows the overflow symbol in place of its digit. The other columns keep their normal blanking. Each answer is registered and appears one clock after the index that asked for it.

Top module: `rdo_digit_readout`

## Requirements
- R1: Digit i of the count sits at `count_digits[4i+3:4i]`. One clock after `scan_col` = i, `digit_code` holds that digit when the column is shown, and a shown code is always a BCD value of 0 to 9.
- R2: A column i > 0 is blanked when digit i and every digit to its left are zero. A blanked column gives `digit_blank` = 1 and `digit_code` = 0.
- R3: A zero digit that has a nonzero digit somewhere to its left is shown as 0, with `digit_blank` = 0.
- R4: Column 0 is never blanked. An all-zero count shows `digit_code` = 0 with `digit_blank` = 0 in column 0, and blanks every other column.
- R5: A one-cycle pulse on `msd_carry` sets the overflow flag at the next edge. The flag then stays set for any number of cycles until a clear.
- R6: `count_clr` clears the overflow flag at the next edge. When the clear and the carry arrive in the same cycle, the clear wins.
- R7: While the flag is set, column 7 answers with `ovf_mark` = 1, `digit_blank` = 0 and `digit_code` = 0, whatever its digit is. `ovf_mark` is 0 in every other case.
- R8: While the flag is set, columns 0 to 6 keep the rules of R1 to R4. The hidden digit 7 still counts when deciding whether the zeros to its right are leading zeros.
- R9: While reset is asserted, the outputs are `digit_code` = 0, `digit_blank` = 1 and `ovf_mark` = 0, and the overflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| count_digits | input | 32 | Eight packed BCD digits, digit 0 in the low nibble |
| msd_carry | input | 1 | Carry pulse out of the most significant decade |
| count_clr | input | 1 | Counter clear, which also clears the overflow flag |
| scan_col | input | 3 | Column index from the external readout scan |
| digit_code | output | 4 | Registered BCD code of the selected column |
| digit_blank | output | 1 | Registered blank flag of the selected column |
| ovf_mark | output | 1 | Registered select of the overflow symbol |

## Verification
The assertions assume that every nibble of `count_digits` is a legal BCD value. The bench builds each nibble by decimal division of a number below 10^8, so no nibble ever goes above 9. The assertions that look back one cycle at the scan index or at the flag are armed only after one clock out of reset. The bench changes the index, the digits, the carry and the clear only on falling edges, so every input is steady at the rising edge that samples it.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  localparam int unsigned DIGIT_W = 4;

  // one column's answer to the scanner
  typedef struct packed {
    logic [DIGIT_W-1:0] code;
    logic               blank;
    logic               mark;
  } rdo_col_t;

endpackage

// File: rtl/rdo_ovf_flag.sv
module rdo_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // clear has priority over a simultaneous carry
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = flag_q;
    if (clr_i) begin
      flag_d = 1'b0;
    end else if (set_i) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rdo_zero_scan.sv
module rdo_zero_scan
  import rdo_pkg::*;
#(
  parameter int unsigned NDIG = 8,
  localparam int unsigned BUS_W = NDIG * DIGIT_W
) (
  input  logic [BUS_W-1:0] digits_i,
  output logic [NDIG-1:0]  blank_o
);

  // run_zero[i]: digit i and every digit to its left are zero
  logic [NDIG:0] run_zero;

  assign run_zero[NDIG] = 1'b1;

  for (genvar i = NDIG - 1; i >= 0; i--) begin : g_run
    assign run_zero[i] = run_zero[i+1] & (digits_i[i*DIGIT_W +: DIGIT_W] == '0);
    if (i == 0) begin : g_lsd
      assign blank_o[i] = 1'b0;
    end else begin : g_upper
      assign blank_o[i] = run_zero[i];
    end
  end

endmodule

// File: rtl/rdo_col_sel.sv
module rdo_col_sel
  import rdo_pkg::*;
#(
  parameter int unsigned NDIG = 8,
  localparam int unsigned COL_W = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int unsigned NSLOT = 1 << COL_W,
  localparam int unsigned BUS_W = NDIG * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] digits_i,
  input  logic [NDIG-1:0]  blank_i,
  input  logic             ovf_i,
  input  logic [COL_W-1:0] col_i,
  output rdo_col_t         col_o
);

  localparam logic [COL_W-1:0] TOP_COL = COL_W'(NDIG - 1);

  logic [DIGIT_W-1:0] slot_code [NSLOT];
  logic [NSLOT-1:0]   slot_blank;
  rdo_col_t           col_d;
  rdo_col_t           col_q;
  logic               col_en;

  // pad unused index slots as blank columns
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s < NDIG) begin : g_real
      assign slot_code[s]  = digits_i[s*DIGIT_W +: DIGIT_W];
      assign slot_blank[s] = blank_i[s];
    end else begin : g_pad
      assign slot_code[s]  = '0;
      assign slot_blank[s] = 1'b1;
    end
  end

  always_comb begin
    col_en      = 1'b1;
    col_d.code  = '0;
    col_d.blank = 1'b0;
    col_d.mark  = 1'b0;
    if (ovf_i && (col_i == TOP_COL)) begin
      col_d.mark = 1'b1;
    end else if (slot_blank[col_i]) begin
      col_d.blank = 1'b1;
    end else begin
      col_d.code = slot_code[col_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q.code  <= '0;
      col_q.blank <= 1'b1;
      col_q.mark  <= 1'b0;
    end else if (col_en) begin
      col_q <= col_d;
    end
  end

  assign col_o = col_q;

endmodule

// File: rtl/rdo_digit_readout.sv
module rdo_digit_readout
  import rdo_pkg::*;
#(
  parameter int unsigned NDIG = 8,
  localparam int unsigned COL_W = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int unsigned BUS_W = NDIG * DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BUS_W-1:0]   count_digits,
  input  logic               msd_carry,
  input  logic               count_clr,
  input  logic [COL_W-1:0]   scan_col,
  output logic [DIGIT_W-1:0] digit_code,
  output logic               digit_blank,
  output logic               ovf_mark
);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            ovf_flag;
  logic [NDIG-1:0] blank_vec;
  rdo_col_t        col_out;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  rdo_ovf_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (msd_carry),
    .clr_i  (count_clr),
    .flag_o (ovf_flag)
  );

  rdo_zero_scan #(.NDIG(NDIG)) u_zscan (
    .digits_i (count_digits),
    .blank_o  (blank_vec)
  );

  rdo_col_sel #(.NDIG(NDIG)) u_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .digits_i (count_digits),
    .blank_i  (blank_vec),
    .ovf_i    (ovf_flag),
    .col_i    (scan_col),
    .col_o    (col_out)
  );

  assign digit_code  = col_out.code;
  assign digit_blank = col_out.blank;
  assign ovf_mark    = col_out.mark;

endmodule

// File: rtl/rdo_readout_chk.sv
module rdo_readout_chk #(
  parameter int unsigned NDIG = 8,
  localparam int unsigned COL_W = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [COL_W-1:0] scan_col,
  input logic             msd_carry,
  input logic             count_clr,
  input logic             ovf_flag,
  input logic [3:0]       digit_code,
  input logic             digit_blank,
  input logic             ovf_mark
);

  logic armed;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  p_lsd_shown_r4: assert property (@(posedge clk) disable iff (!rst_sync_n || !armed)
    ($past(scan_col) == '0) |-> !digit_blank);

  p_mark_col_r7: assert property (@(posedge clk) disable iff (!rst_sync_n || !armed)
    ovf_mark |-> (($past(scan_col) == COL_W'(NDIG - 1)) && $past(ovf_flag)));

  p_mark_excl_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_mark |-> (!digit_blank && (digit_code == 4'd0)));

  p_blank_code_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    digit_blank |-> (digit_code == 4'd0));

  p_bcd_code_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !digit_blank |-> (digit_code <= 4'd9));

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (msd_carry && !count_clr) |=> ovf_flag);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_flag && !count_clr) |=> ovf_flag);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    count_clr |=> !ovf_flag);

endmodule

bind rdo_digit_readout rdo_readout_chk #(.NDIG(NDIG)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .scan_col    (scan_col),
  .msd_carry   (msd_carry),
  .count_clr   (count_clr),
  .ovf_flag    (ovf_flag),
  .digit_code  (digit_code),
  .digit_blank (digit_blank),
  .ovf_mark    (ovf_mark)
);

// File: tb/tb_rdo_digit_readout.sv
module tb_rdo_digit_readout;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NDIG = 8;

  logic        clk;
  logic        rst_n;
  logic [31:0] count_digits;
  logic        msd_carry;
  logic        count_clr;
  logic [2:0]  scan_col;
  logic [3:0]  digit_code;
  logic        digit_blank;
  logic        ovf_mark;

  int  n_chk;
  int  n_fail;
  bit  done;
  bit  ovf_exp;

  rdo_digit_readout #(.NDIG(NDIG)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_digits (count_digits),
    .msd_carry    (msd_carry),
    .count_clr    (count_clr),
    .scan_col     (scan_col),
    .digit_code   (digit_code),
    .digit_blank  (digit_blank),
    .ovf_mark     (ovf_mark)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  function automatic longint pow10(int e);
    longint p = 1;
    for (int k = 0; k < e; k++) p = p * 10;
    return p;
  endfunction

  function automatic logic [31:0] to_bcd(longint v);
    logic [31:0] b = '0;
    for (int k = 0; k < NDIG; k++) b[k*4 +: 4] = 4'((v / pow10(k)) % 10);
    return b;
  endfunction

  task automatic check(string req, logic [3:0] c, logic b, logic m,
                       logic [3:0] ec, logic eb, logic em);
    n_chk++;
    if (c !== ec || b !== eb || m !== em) begin
      n_fail++;
      $display("FAIL %s: code/blank/mark = %0d/%0b/%0b, expected %0d/%0b/%0b",
               req, c, b, m, ec, eb, em);
    end
  endtask

  // entered at a falling edge, leaves at a falling edge
  task automatic probe(longint v, int col);
    longint     pw;
    int         d;
    logic       eb;
    logic       em;
    logic [3:0] ec;
    string      req;
    count_digits = to_bcd(v);
    scan_col     = 3'(col);
    @(negedge clk);
    pw = pow10(col);
    d  = int'((v / pw) % 10);
    em = ovf_exp && (col == NDIG - 1);
    eb = !em && (col > 0) && (v < pw);
    ec = (eb || em) ? 4'd0 : 4'(d);
    if (em)                   req = "R7";
    else if (ovf_exp)         req = "R8";
    else if (eb)              req = "R2";
    else if (col == 0)        req = "R4";
    else if (d == 0)          req = "R3";
    else                      req = "R1";
    check(req, digit_code, digit_blank, ovf_mark, ec, eb, em);
  endtask

  task automatic sweep(longint v);
    for (int col = 0; col < NDIG; col++) probe(v, col);
  endtask

  task automatic sweep_set();
    longint fixed [12] = '{0, 1, 7, 10, 100, 1000000, 10000000, 99999999,
                           20030004, 90000000, 45000600, 305};
    logic [31:0] lfsr = 32'hACE1_1234;
    foreach (fixed[k]) sweep(fixed[k]);
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      // vary magnitude so many leading-zero lengths appear
      sweep(longint'(lfsr) % pow10(k % 9));
    end
  endtask

  initial begin
    done = 1'b0;
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk        = 0;
    n_fail       = 0;
    ovf_exp      = 1'b0;
    rst_n        = 1'b0;
    count_digits = '0;
    msd_carry    = 1'b0;
    count_clr    = 1'b0;
    scan_col     = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", digit_code, digit_blank, ovf_mark, 4'd0, 1'b1, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1..R4 with no overflow
    sweep_set();

    // R5: one-cycle carry pulse, then hold for a while
    msd_carry = 1'b1;
    @(negedge clk);
    msd_carry = 1'b0;
    ovf_exp   = 1'b1;
    repeat (20) @(negedge clk);
    // R7, R8 under overflow, also checks stickiness of R5
    sweep_set();

    // R6: clear drops the flag
    count_clr = 1'b1;
    @(negedge clk);
    count_clr = 1'b0;
    ovf_exp   = 1'b0;
    sweep(99999999);
    sweep(0);

    // R6: clear and carry together, clear wins
    count_clr = 1'b1;
    msd_carry = 1'b1;
    @(negedge clk);
    count_clr = 1'b0;
    msd_carry = 1'b0;
    probe(50000000, NDIG - 1);
    probe(0, NDIG - 1);

    // R5 again from a cleared state, R7 with zero count
    msd_carry = 1'b1;
    @(negedge clk);
    msd_carry = 1'b0;
    ovf_exp   = 1'b1;
    sweep(0);
    sweep(80000000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule